// File: doc/BRIEF.md
# Peripheral Access Protection Gate

This block sits between a bus fabric and a bank of peripheral slave ports and decides, for every incoming transaction, whether it may reach its target. The fabric presents a port index that has already been decoded, together with address, direction, transfer size, write data, a secure attribute and a user-mode attribute. Each port has two configuration bits. One says whether the port belongs to the non-secure world. The other says whether unprivileged code may touch it. A static mask set at build time can exempt chosen ports from the secure-world test.

Permitted transactions are passed to the selected downstream port, and that port's completion comes back unchanged. A refused transaction never reaches a slave. It completes at once, either with an error or as a successful read-as-zero / write-ignored access, as chosen by one global select. Every refusal latches a sticky violation flag. That flag is gated by an enable level to form the interrupt. A clear level empties the flag and, while held, keeps it empty.

Top module: `periph_guard`

## Requirements
- R1: For a port whose mask bit is 0, an access is refused when its secure attribute (1 = secure) equals the port's non-secure configuration bit (1 = port is non-secure).
- R2: For a port whose bit in the static bypass mask is 1, the secure attribute is never a reason to refuse the access.
- R3: An access with the user attribute at 1 is refused when the port's user-permission bit is 0, whatever the outcome of the secure test.
- R4: A refused access raises no downstream request and sees upstream ready high in the same cycle that valid is presented.
- R5: When the error-select bit is 1, a refused access completes with up_err = 1. When it is 0, a refused access completes with up_err = 0 and read data 0, and a refused write reaches no slave.
- R6: Completion of a refused access sets a sticky violation flag from the next clock edge on. Later permitted accesses leave the flag set.
- R7: While irq_clr is high, the violation flag is 0 from the next edge on, and refused accesses do not set it. After irq_clr falls, the flag stays 0 until a new refusal.
- R8: irq is the AND of the violation flag and the irq_en level, and follows irq_en within the same cycle.
- R9: While reset is active, the registered copies of the non-secure bits, the user-permission bits and the error-select bit are all 0, and the violation flag is 0.
- R10: A permitted access raises exactly the dn_req bit of its port index. It holds up_ready low until that port's dn_ack. It returns that port's dn_err and read data unchanged. dn_be has its low 2^size bits set (size code 0,1,2,3 = 1,2,4,8 bytes), with byte i of the LSB-aligned data on lane i.
- R11: The configuration inputs are registered. An access is judged by the values captured at the most recent clock edge, not by the current input levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream request valid |
| up_port | input | IDX_W | Decoded target port index |
| up_addr | input | ADDR_W | Offset within the port |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Size code: 0..3 = 1,2,4,8 bytes |
| up_wdata | input | DATA_W | LSB-aligned write data |
| up_secure | input | 1 | 1 = secure transaction |
| up_user | input | 1 | 1 = unprivileged transaction |
| up_ready | output | 1 | Upstream completion strobe |
| up_err | output | 1 | Error response on completion |
| up_rdata | output | DATA_W | Read data on completion |
| dn_req | output | NUM_PORTS | One-hot downstream request |
| dn_addr | output | ADDR_W | Shared downstream address |
| dn_write | output | 1 | Shared downstream direction |
| dn_size | output | 2 | Shared downstream size code |
| dn_be | output | LANES | Byte lane enables |
| dn_wdata | output | DATA_W | Shared downstream write data |
| dn_ack | input | NUM_PORTS | Per-port completion |
| dn_err | input | NUM_PORTS | Per-port error response |
| dn_rdata | input | NUM_PORTS*DATA_W | Per-port read data, port p at bits p*DATA_W |
| cfg_nonsec | input | NUM_PORTS | Per-port non-secure bit |
| cfg_user_ok | input | NUM_PORTS | Per-port user-permission bit |
| cfg_err_sel | input | 1 | 1 = error on refusal, 0 = read-as-zero / write-ignored |
| irq_en | input | 1 | Interrupt enable level |
| irq_clr | input | 1 | Violation clear level |
| irq | output | 1 | Violation interrupt |

## Verification
The assertions assume that the upstream port index is below NUM_PORTS and that each slave raises dn_ack only while its own dn_req is high. The bench's slave model acks only a live request, after a latency of port-index modulo 3 cycles, and every port index it drives is in range. The assertions do not rely on request fields staying stable during a pending access. One deliberate case changes the configuration while a permitted access is still waiting, to show that the registered copy governs the decision.

// File: rtl/guard_pkg.sv
`timescale 1ns/1ps
package guard_pkg;
   typedef enum logic [1:0] {
      XS_BYTE  = 2'd0,
      XS_HALF  = 2'd1,
      XS_WORD  = 2'd2,
      XS_DWORD = 2'd3
   } xfer_size_e;

   function automatic int unsigned size_bytes(input logic [1:0] code);
      return 32'd1 << code;
   endfunction
endpackage

// File: rtl/guard_cfg.sv
`timescale 1ns/1ps
module guard_cfg #(
   parameter int NUM_PORTS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] cfg_nonsec,
   input  logic [NUM_PORTS-1:0] cfg_user_ok,
   input  logic                 cfg_err_sel,
   output logic [NUM_PORTS-1:0] nonsec_q,
   output logic [NUM_PORTS-1:0] user_ok_q,
   output logic                 err_sel_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nonsec_q  <= '0;
         user_ok_q <= '0;
         err_sel_q <= 1'b0;
      end else begin
         nonsec_q  <= cfg_nonsec;
         user_ok_q <= cfg_user_ok;
         err_sel_q <= cfg_err_sel;
      end
   end
endmodule

// File: rtl/guard_rule.sv
`timescale 1ns/1ps
module guard_rule #(
   parameter int                   NUM_PORTS   = 16,
   parameter logic [NUM_PORTS-1:0] BYPASS_MASK = '0
) (
   input  logic                 secure,
   input  logic                 user,
   input  logic [NUM_PORTS-1:0] nonsec_q,
   input  logic [NUM_PORTS-1:0] user_ok_q,
   output logic [NUM_PORTS-1:0] deny
);
   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic world_fail;
      logic priv_fail;
      if (BYPASS_MASK[p]) begin : g_bypass
         assign world_fail = 1'b0;
      end else begin : g_checked
         assign world_fail = (secure == nonsec_q[p]);
      end
      assign priv_fail = user & ~user_ok_q[p];
      assign deny[p]   = world_fail | priv_fail;
   end
endmodule

// File: rtl/guard_route.sv
`timescale 1ns/1ps
module guard_route #(
   parameter int NUM_PORTS = 16,
   parameter int DATA_W    = 64,
   parameter int IDX_W     = 4,
   localparam int LANES    = DATA_W / 8
) (
   input  logic                          fwd,
   input  logic [IDX_W-1:0]              port,
   input  logic [1:0]                    size,
   input  logic [NUM_PORTS-1:0]          dn_ack,
   input  logic [NUM_PORTS-1:0]          dn_err,
   input  logic [NUM_PORTS*DATA_W-1:0]   dn_rdata,
   output logic [NUM_PORTS-1:0]          dn_req,
   output logic [LANES-1:0]              dn_be,
   output logic                          rt_ack,
   output logic                          rt_err,
   output logic [DATA_W-1:0]             rt_rdata
);
   import guard_pkg::*;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
      assign dn_req[p] = fwd && (port == IDX_W'(p));
   end

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         dn_be[i] = (i < int'(size_bytes(size)));
      end
   end

   always_comb begin
      rt_ack   = 1'b0;
      rt_err   = 1'b0;
      rt_rdata = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (dn_req[p]) begin
            rt_ack   = dn_ack[p];
            rt_err   = dn_err[p];
            rt_rdata = dn_rdata[p*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/guard_status.sv
`timescale 1ns/1ps
module guard_status (
   input  logic clk,
   input  logic rst_n,
   input  logic viol,
   input  logic irq_en,
   input  logic irq_clr,
   output logic flag_q,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (irq_clr) flag_q <= 1'b0;
      else if (viol)    flag_q <= 1'b1;
   end

   assign irq = flag_q & irq_en;
endmodule

// File: rtl/periph_guard.sv
`timescale 1ns/1ps
module periph_guard #(
   parameter int                   NUM_PORTS   = 16,
   parameter int                   ADDR_W      = 32,
   parameter int                   DATA_W      = 64,
   parameter logic [NUM_PORTS-1:0] BYPASS_MASK = '0,
   localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int LANES = DATA_W / 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        up_valid,
   input  logic [IDX_W-1:0]            up_port,
   input  logic [ADDR_W-1:0]           up_addr,
   input  logic                        up_write,
   input  logic [1:0]                  up_size,
   input  logic [DATA_W-1:0]           up_wdata,
   input  logic                        up_secure,
   input  logic                        up_user,
   output logic                        up_ready,
   output logic                        up_err,
   output logic [DATA_W-1:0]           up_rdata,
   output logic [NUM_PORTS-1:0]        dn_req,
   output logic [ADDR_W-1:0]           dn_addr,
   output logic                        dn_write,
   output logic [1:0]                  dn_size,
   output logic [LANES-1:0]            dn_be,
   output logic [DATA_W-1:0]           dn_wdata,
   input  logic [NUM_PORTS-1:0]        dn_ack,
   input  logic [NUM_PORTS-1:0]        dn_err,
   input  logic [NUM_PORTS*DATA_W-1:0] dn_rdata,
   input  logic [NUM_PORTS-1:0]        cfg_nonsec,
   input  logic [NUM_PORTS-1:0]        cfg_user_ok,
   input  logic                        cfg_err_sel,
   input  logic                        irq_en,
   input  logic                        irq_clr,
   output logic                        irq
);
   localparam int SPAN = 1 << IDX_W;

   if (NUM_PORTS < 1 || NUM_PORTS > 64) begin : g_bad_ports
      $error("periph_guard: NUM_PORTS out of range");
   end
   if (DATA_W < 64 || (DATA_W % 8) != 0) begin : g_bad_data
      $error("periph_guard: DATA_W must be a byte multiple of at least 64");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("periph_guard: ADDR_W must be positive");
   end

   logic [NUM_PORTS-1:0] nonsec_q, user_ok_q, deny;
   logic                 err_sel_q;
   logic [SPAN-1:0]      deny_span;
   logic                 sel_deny, fwd;
   logic                 rt_ack, rt_err;
   logic [DATA_W-1:0]    rt_rdata;
   logic                 flag_q;

   guard_cfg #(.NUM_PORTS(NUM_PORTS)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .cfg_nonsec(cfg_nonsec), .cfg_user_ok(cfg_user_ok), .cfg_err_sel(cfg_err_sel),
      .nonsec_q(nonsec_q), .user_ok_q(user_ok_q), .err_sel_q(err_sel_q)
   );

   guard_rule #(.NUM_PORTS(NUM_PORTS), .BYPASS_MASK(BYPASS_MASK)) u_rule (
      .secure(up_secure), .user(up_user),
      .nonsec_q(nonsec_q), .user_ok_q(user_ok_q), .deny(deny)
   );

   // Indices beyond the populated ports are always refused.
   if (SPAN > NUM_PORTS) begin : g_pad
      assign deny_span = {{(SPAN-NUM_PORTS){1'b1}}, deny};
   end else begin : g_nopad
      assign deny_span = deny;
   end

   assign sel_deny = deny_span[up_port];
   assign fwd      = up_valid && !sel_deny;

   guard_route #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_route (
      .fwd(fwd), .port(up_port), .size(up_size),
      .dn_ack(dn_ack), .dn_err(dn_err), .dn_rdata(dn_rdata),
      .dn_req(dn_req), .dn_be(dn_be),
      .rt_ack(rt_ack), .rt_err(rt_err), .rt_rdata(rt_rdata)
   );

   assign dn_addr  = up_addr;
   assign dn_write = up_write;
   assign dn_size  = up_size;
   assign dn_wdata = up_wdata;

   assign up_ready = up_valid && (sel_deny || rt_ack);
   assign up_err   = sel_deny ? err_sel_q : rt_err;
   assign up_rdata = sel_deny ? '0 : rt_rdata;

   guard_status u_status (
      .clk(clk), .rst_n(rst_n),
      .viol(up_valid && sel_deny),
      .irq_en(irq_en), .irq_clr(irq_clr),
      .flag_q(flag_q), .irq(irq)
   );
endmodule

// File: rtl/guard_chk.sv
`timescale 1ns/1ps
module guard_chk #(
   parameter int NUM_PORTS = 16,
   parameter int DATA_W    = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 up_valid,
   input logic                 up_ready,
   input logic                 up_err,
   input logic [DATA_W-1:0]    up_rdata,
   input logic [NUM_PORTS-1:0] dn_req,
   input logic                 sel_deny,
   input logic                 err_sel_q,
   input logic                 irq,
   input logic                 irq_en,
   input logic                 irq_clr
);
   AST_DENY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && sel_deny) |-> (dn_req == '0 && up_ready)); // R4
   AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dn_req)); // R10
   AST_DENY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && sel_deny && err_sel_q) |-> (up_ready && up_err)); // R5
   AST_DENY_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && sel_deny && !err_sel_q) |-> (up_ready && !up_err && up_rdata == '0)); // R5
   AST_VIOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && sel_deny && !irq_clr && irq_en) |=> (irq || !irq_en)); // R6
   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> (irq || !irq_en)); // R6
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr |=> !irq); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq); // R8
endmodule

bind periph_guard guard_chk #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
   .up_err(up_err), .up_rdata(up_rdata), .dn_req(dn_req), .sel_deny(sel_deny),
   .err_sel_q(err_sel_q), .irq(irq), .irq_en(irq_en), .irq_clr(irq_clr)
);

// File: tb/sim_periph_guard.sv
`timescale 1ns/1ps
module sim_periph_guard;
   localparam int          NP   = 16;
   localparam int          AW   = 32;
   localparam int          DW   = 64;
   localparam logic [15:0] MASK = 16'h8001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            up_valid = 1'b0, up_write = 1'b0, up_secure = 1'b0, up_user = 1'b0;
   logic [3:0]      up_port = '0;
   logic [AW-1:0]   up_addr = '0;
   logic [1:0]      up_size = '0;
   logic [DW-1:0]   up_wdata = '0;
   logic            up_ready, up_err;
   logic [DW-1:0]   up_rdata;
   logic [NP-1:0]   dn_req, dn_ack, dn_err;
   logic [AW-1:0]   dn_addr;
   logic            dn_write;
   logic [1:0]      dn_size;
   logic [7:0]      dn_be;
   logic [DW-1:0]   dn_wdata;
   logic [NP*DW-1:0] dn_rdata;
   logic [NP-1:0]   cfg_nonsec = '0, cfg_user_ok = '0;
   logic            cfg_err_sel = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
   logic            irq;

   periph_guard #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .BYPASS_MASK(MASK)) u0 (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_port(up_port),
      .up_addr(up_addr), .up_write(up_write), .up_size(up_size), .up_wdata(up_wdata),
      .up_secure(up_secure), .up_user(up_user), .up_ready(up_ready), .up_err(up_err),
      .up_rdata(up_rdata), .dn_req(dn_req), .dn_addr(dn_addr), .dn_write(dn_write),
      .dn_size(dn_size), .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_ack(dn_ack),
      .dn_err(dn_err), .dn_rdata(dn_rdata), .cfg_nonsec(cfg_nonsec),
      .cfg_user_ok(cfg_user_ok), .cfg_err_sel(cfg_err_sel), .irq_en(irq_en),
      .irq_clr(irq_clr), .irq(irq)
   );

   // Slave model: port p acks after p%3 wait cycles; addr bit 8 requests an error.
   function automatic logic [DW-1:0] slave_data(input int p, input logic [AW-1:0] a);
      return 64'hC3A5_0000_0000_0000 | (64'(p) << 40) | 64'(a);
   endfunction

   logic [1:0] wait_cnt [NP];
   always_ff @(posedge clk) begin
      for (int p = 0; p < NP; p++) begin
         if (!rst_n || !dn_req[p] || dn_ack[p]) wait_cnt[p] <= 2'd0;
         else                                   wait_cnt[p] <= wait_cnt[p] + 2'd1;
      end
   end
   always_comb begin
      for (int p = 0; p < NP; p++) begin
         dn_ack[p] = dn_req[p] && (wait_cnt[p] == 2'(p % 3));
         dn_err[p] = dn_req[p] && dn_addr[8];
         dn_rdata[p*DW +: DW] = slave_data(p, dn_addr);
      end
   end

   int            wr_port = -1;
   logic [DW-1:0] wr_data = '0;
   logic [7:0]    wr_be = '0;
   always_ff @(posedge clk) begin
      for (int p = 0; p < NP; p++) begin
         if (dn_ack[p] && dn_write) begin
            wr_port <= p;
            wr_data <= dn_wdata;
            wr_be   <= dn_be;
         end
      end
   end

   int n_tests = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint unsigned act, input longint unsigned exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [NP-1:0] ns, input logic [NP-1:0] uo, input logic es);
      @(negedge clk);
      cfg_nonsec = ns; cfg_user_ok = uo; cfg_err_sel = es;
      @(posedge clk);
   endtask

   // Presents one access at a negedge; returns wait cycles, response and whether a request was seen.
   task automatic access(input int p, input bit wr, input logic [1:0] sz,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input bit sec, input bit usr,
                         output int cyc, output logic err, output logic [DW-1:0] rd,
                         output bit saw_req);
      @(negedge clk);
      up_valid = 1'b1; up_port = 4'(p); up_write = wr; up_size = sz;
      up_addr = a; up_wdata = wd; up_secure = sec; up_user = usr;
      cyc = 0; saw_req = 1'b0;
      while (1) begin
         #1;
         if (dn_req != '0) saw_req = 1'b1;
         if (up_ready || cyc > 20) break;
         cyc++;
         @(negedge clk);
      end
      err = up_err; rd = up_rdata;
      @(posedge clk);
      #1 up_valid = 1'b0;
   endtask

   initial begin
      int            cyc;
      logic          err;
      logic [DW-1:0] rd;
      bit            saw;

      // R9: during reset the registered configuration is all zero.
      cfg_nonsec = '1; cfg_user_ok = '1; cfg_err_sel = 1'b1; irq_en = 1'b1;
      up_valid = 1'b1; up_port = 4'd3; up_secure = 1'b1; up_user = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(up_ready == 1'b1, "R9", "user access refused in reset (ready)", up_ready, 1);
      chk(up_err == 1'b0, "R9", "error select reg zero in reset", up_err, 0);
      chk(dn_req == '0, "R9", "no request in reset", dn_req, 0);
      chk(irq == 1'b0, "R9", "flag zero in reset", irq, 0);
      up_user = 1'b0;
      #1;
      chk(dn_req == 16'h0008, "R9", "secure priv access allowed with nonsec reg zero", dn_req, 16'h0008);
      up_valid = 1'b0; irq_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R3 R4 R10: sweep of ports, per-port config pattern, attributes.
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < 4; c++) begin
            logic [NP-1:0] ns, uo;
            ns = c[0] ? (NP'(1) << p) : ~(NP'(1) << p);
            uo = c[1] ? (NP'(1) << p) : ~(NP'(1) << p);
            set_cfg(ns, uo, 1'b0);
            for (int s = 0; s < 2; s++) begin
               for (int u = 0; u < 2; u++) begin
                  bit    wfail, pfail, deny;
                  string tag;
                  logic [AW-1:0] a;
                  wfail = !MASK[p] && (s == c[0]);
                  pfail = (u == 1) && (c[1] == 0);
                  deny  = wfail || pfail;
                  tag   = pfail ? "R3" : (MASK[p] ? "R2" : "R1");
                  a     = AW'(32'h1000 + p * 16 + c * 4 + s * 2 + u);
                  access(p, 1'b0, 2'd2, a, '0, s[0], u[0], cyc, err, rd, saw);
                  if (deny) begin
                     chk(cyc == 0, "R4", {tag, " refused completes at once"}, cyc, 0);
                     chk(!saw, "R4", {tag, " refused raises no request"}, saw, 0);
                     chk(err == 1'b0 && rd == '0, "R5", {tag, " read-as-zero"}, rd, 0);
                  end else begin
                     chk(cyc == p % 3, "R10", {tag, " permitted waits for slave"}, cyc, p % 3);
                     chk(rd == slave_data(p, a), "R10", {tag, " permitted read data"}, rd, slave_data(p, a));
                     chk(err == 1'b0, "R10", {tag, " permitted ok response"}, err, 0);
                  end
               end
            end
         end
      end

      // R10: permitted writes of every size reach the right port with lane enables.
      set_cfg('0, '1, 1'b0);
      for (int p = 0; p < NP; p += 3) begin
         for (int sz = 0; sz < 4; sz++) begin
            logic [DW-1:0] wd;
            logic [7:0]    be;
            wd = 64'h0102_0304_0506_0708 ^ (64'(p) << 56) ^ 64'(sz);
            be = 8'((16'd1 << (1 << sz)) - 16'd1);
            access(p, 1'b1, 2'(sz), AW'(32'h40), wd, 1'b1, 1'b0, cyc, err, rd, saw);
            chk(wr_port == p, "R10", "write reached port", wr_port, p);
            chk(wr_data == wd, "R10", "write data unchanged", wr_data, wd);
            chk(wr_be == be, "R10", "byte lanes from size", wr_be, be);
         end
      end
      access(7, 1'b0, 2'd3, AW'(32'h100), '0, 1'b1, 1'b0, cyc, err, rd, saw);
      chk(err == 1'b1, "R10", "slave error passed back", err, 1);

      // R5: error select and write suppression.
      wr_port = -1;
      set_cfg('0, '0, 1'b0);
      access(9, 1'b1, 2'd3, AW'(32'h0), 64'hDEAD, 1'b1, 1'b1, cyc, err, rd, saw);
      @(negedge clk);
      chk(wr_port == -1, "R5", "refused write not forwarded", wr_port, -1);
      chk(err == 1'b0, "R5", "refused write ok response", err, 0);
      set_cfg('0, '0, 1'b1);
      for (int p = 0; p < NP; p++) begin
         access(p, p[0], 2'd2, AW'(32'h0), 64'h55, 1'b1, 1'b1, cyc, err, rd, saw);
         chk(err == 1'b1 && cyc == 0 && !saw, "R5", "refusal with error select", err, 1);
      end
      @(negedge clk);
      chk(wr_port == -1, "R5", "no refused write reached a slave", wr_port, -1);

      // R11: configuration is taken from the registered copy.
      set_cfg('0, '1, 1'b1);
      @(negedge clk);
      cfg_user_ok = '0;
      up_valid = 1'b1; up_port = 4'd4; up_write = 1'b0; up_size = 2'd0;
      up_addr = '0; up_secure = 1'b1; up_user = 1'b1;
      #1;
      chk(dn_req == 16'h0010 && !up_ready, "R11", "old permission still in force", dn_req, 16'h0010);
      @(negedge clk);
      #1;
      chk(up_ready && up_err && dn_req == '0, "R11", "new permission after edge", up_err, 1);
      @(posedge clk);
      #1 up_valid = 1'b0;

      // R6 R7 R8: sticky violation flag and interrupt.
      set_cfg('0, '0, 1'b0);
      irq_en = 1'b1;
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      #1;
      chk(irq == 1'b0, "R7", "clear empties flag", irq, 0);
      access(2, 1'b0, 2'd0, '0, '0, 1'b1, 1'b1, cyc, err, rd, saw);
      chk(irq == 1'b1, "R6", "refusal sets flag", irq, 1);
      access(0, 1'b0, 2'd0, '0, '0, 1'b1, 1'b0, cyc, err, rd, saw);
      @(negedge clk);
      chk(irq == 1'b1, "R6", "flag sticky across permitted access", irq, 1);
      irq_en = 1'b0;
      #1;
      chk(irq == 1'b0, "R8", "enable low gates irq", irq, 0);
      irq_en = 1'b1;
      #1;
      chk(irq == 1'b1, "R8", "enable high shows flag", irq, 1);
      @(negedge clk); irq_clr = 1'b1;
      access(5, 1'b0, 2'd0, '0, '0, 1'b1, 1'b1, cyc, err, rd, saw);
      chk(irq == 1'b0, "R7", "held clear blocks new set", irq, 0);
      @(negedge clk); irq_clr = 1'b0;
      @(negedge clk);
      #1;
      chk(irq == 1'b0, "R7", "flag stays clear after release", irq, 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule